// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the test access port of a synchronous memory device. A serial test controller drives the test clock, mode select and data input. The block walks the usual sixteen-state controller, holds a 3-bit instruction, and places one of three data registers between the serial input and output. The three data registers are a 1-bit bypass cell, a 32-bit identification word and a boundary-scan chain whose length depends on the package.

The pad ring is modelled as two parallel vectors. `pin_capture` is sampled into the chain, and `pin_update` is the value loaded out of it. `out_hiz` tells the memory to float its data drivers. Two parameters select the variant. `ALT_PACKAGE` picks an 85-cell chain (0) or an 89-cell chain (1), and it also sets the package-dependent identification field. `NARROW` picks the x36 (0) or x18 (1) device code.

Controller states, with the next state for TMS = 0 / TMS = 1:

| State | TMS = 0 | TMS = 1 |
|---|---|---|
| TLR | RTI | TLR |
| RTI | RTI | SEL_DR |
| SEL_DR | CAP_DR | SEL_IR |
| CAP_DR | SH_DR | EX1_DR |
| SH_DR | SH_DR | EX1_DR |
| EX1_DR | PAU_DR | UPD_DR |
| PAU_DR | PAU_DR | EX2_DR |
| EX2_DR | SH_DR | UPD_DR |
| UPD_DR | RTI | SEL_DR |
| SEL_IR | CAP_IR | TLR |

The instruction-side states CAP_IR through UPD_IR mirror the CAP_DR through UPD_DR rows.

Top module: `sram_tap_port`

## Requirements
- R1: The controller follows the state table above on each rising `tck`. It enters TLR when `trst_n` is low, and it also enters TLR after five rising edges with `tms` high from any state.
- R2: While the controller is in TLR, the active instruction is IDCODE (001) and `out_hiz` is low.
- R3: CAP_IR loads binary 001 into the instruction shift register. The register shifts least significant bit first toward `tdo`, so the first three bits out are 1, 0, 0.
- R4: The active instruction changes only on the rising edge that leaves UPD_IR, or in TLR. Shifting a new code leaves `out_hiz` unchanged until that edge.
- R5: IDCODE (001) selects the 32-bit identification word, which is captured in CAP_DR. Its fields are: bits 31:29 = 000; bits 28:24 = 01011; bits 23:18 = 101000 for the 85-cell package or 000000 for the 89-cell package; bits 11:1 = 00000110100; bit 0 = 1.
- R6: BYPASS (111) and the reserved codes 011, 101 and 110 select a single bypass cell. That cell loads 0 in CAP_DR.
- R7: Codes 000 (EXTEST), 010 (sample with outputs floated) and 100 (sample/preload) select the boundary chain. The chain loads `pin_capture` in CAP_DR, and bit 0 is the bit nearest `tdo`. The chain length is 85 or 89 cells.
- R8: On leaving UPD_DR under a chain instruction, `pin_update` takes the chain contents. Under any other instruction, `pin_update` is unchanged.
- R9: `out_hiz` is high exactly while the active instruction is 000 or 010.
- R10: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is high only while the controller is in SH_IR or SH_DR.
- R11: Bits 17:12 of the identification word are 100101 when `NARROW` = 0 and 010101 when `NARROW` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| pin_capture | input | CELLS | Pad values sampled into the chain |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo` (low means high impedance) |
| pin_update | output | CELLS | Chain values presented to the pads |
| out_hiz | output | 1 | Forces memory data outputs to high impedance |

## Verification
The assertions check several properties on every cycle. They cover the TLR hold and the exit from SEL_IR, and they check that the instruction is stable outside UPD_IR and TLR and that IDCODE is loaded in TLR. They also check that the bypass cell and identification word capture correctly, that `pin_update` holds outside UPD_DR, and that `tdo_oe` is tied to the shift states. Register lengths, the field values of the identification word for both variants, and the full decode of all eight codes can only be shown by the bench's serial scans. The same holds for the masking of the update vector and the five-TMS return to TLR.

// File: rtl/sram_tap_pkg.sv
package sram_tap_pkg;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    localparam int IR_W = 3;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST    = 3'b000,
        OP_IDCODE    = 3'b001,
        OP_PROBE_HIZ = 3'b010,
        OP_RSV_3     = 3'b011,
        OP_PRELOAD   = 3'b100,
        OP_RSV_5     = 3'b101,
        OP_RSV_6     = 3'b110,
        OP_BYPASS    = 3'b111
    } tap_op_e;

    typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    function automatic dr_sel_e decode_sel(tap_op_e op);
        unique case (op)
            OP_EXTEST, OP_PROBE_HIZ, OP_PRELOAD: return SEL_BSR;
            OP_IDCODE:                           return SEL_ID;
            default:                             return SEL_BYP;
        endcase
    endfunction

    function automatic logic floats_outputs(tap_op_e op);
        return (op == OP_EXTEST) || (op == OP_PROBE_HIZ);
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import sram_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TLR;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TLR:    nxt = tms ? TLR    : RTI;
            RTI:    nxt = tms ? SEL_DR : RTI;
            SEL_DR: nxt = tms ? SEL_IR : CAP_DR;
            CAP_DR: nxt = tms ? EX1_DR : SH_DR;
            SH_DR:  nxt = tms ? EX1_DR : SH_DR;
            EX1_DR: nxt = tms ? UPD_DR : PAU_DR;
            PAU_DR: nxt = tms ? EX2_DR : PAU_DR;
            EX2_DR: nxt = tms ? UPD_DR : SH_DR;
            UPD_DR: nxt = tms ? SEL_DR : RTI;
            SEL_IR: nxt = tms ? TLR    : CAP_IR;
            CAP_IR: nxt = tms ? EX1_IR : SH_IR;
            SH_IR:  nxt = tms ? EX1_IR : SH_IR;
            EX1_IR: nxt = tms ? UPD_IR : PAU_IR;
            PAU_IR: nxt = tms ? EX2_IR : PAU_IR;
            EX2_IR: nxt = tms ? UPD_IR : SH_IR;
            UPD_IR: nxt = tms ? SEL_DR : RTI;
            default: nxt = TLR;
        endcase
    end

    AST_TLR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TLR && tms) |=> state == TLR);  // R1
    AST_SELIR_ESCAPE: assert property (@(posedge tck) disable iff (!trst_n)
        (state == SEL_IR && tms) |=> state == TLR);  // R1

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import sram_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output tap_op_e    op,
    output logic       ir_so,
    output logic       out_hiz
);

    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh <= IR_CAPTURE;
            op    <= OP_IDCODE;
        end else if (state == TLR) begin
            op    <= OP_IDCODE;
        end else begin
            unique case (state)
                CAP_IR:  ir_sh <= IR_CAPTURE;
                SH_IR:   ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                UPD_IR:  op    <= tap_op_e'(ir_sh);
                default: ;
            endcase
        end
    end

    always_comb begin
        ir_so   = ir_sh[0];
        out_hiz = floats_outputs(op);
    end

    AST_IR_STABLE: assert property (@(posedge tck) disable iff (!trst_n)
        (state != UPD_IR && state != TLR) |=> $stable(op));  // R4
    AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TLR) |=> (op == OP_IDCODE && !out_hiz));  // R2
    AST_CAPIR_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
        (state == CAP_IR) |=> ir_sh == IR_CAPTURE);  // R3

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import sram_tap_pkg::*;
#(
    parameter int          CELLS   = 85,
    parameter logic [31:0] ID_WORD = 32'h1
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_e       state,
    input  tap_op_e          op,
    input  logic             tdi,
    input  logic [CELLS-1:0] pin_capture,
    output logic             dr_so,
    output logic [CELLS-1:0] pin_update
);

    dr_sel_e          sel;
    logic             byp_q;
    logic [31:0]      id_q;
    logic [CELLS-1:0] bsr_q;
    logic [CELLS:0]   chain;

    assign sel        = decode_sel(op);
    assign chain[CELLS] = tdi;

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        assign chain[k] = bsr_q[k];
        always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n) begin
                bsr_q[k]      <= 1'b0;
                pin_update[k] <= 1'b0;
            end else if (sel == SEL_BSR) begin
                unique case (state)
                    CAP_DR:  bsr_q[k]      <= pin_capture[k];
                    SH_DR:   bsr_q[k]      <= chain[k+1];
                    UPD_DR:  pin_update[k] <= bsr_q[k];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
            id_q  <= ID_WORD;
        end else begin
            unique case (state)
                CAP_DR: begin
                    byp_q <= 1'b0;
                    id_q  <= ID_WORD;
                end
                SH_DR: begin
                    byp_q <= tdi;
                    id_q  <= {tdi, id_q[31:1]};
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ID:  dr_so = id_q[0];
            SEL_BSR: dr_so = bsr_q[0];
            default: dr_so = byp_q;
        endcase
    end

    AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
        (state == CAP_DR) |=> !byp_q);  // R6
    AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
        (state == CAP_DR) |=> id_q == ID_WORD);  // R5
    AST_UPD_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (state != UPD_DR) |=> $stable(pin_update));  // R8

endmodule

// File: rtl/sram_tap_port.sv
module sram_tap_port
    import sram_tap_pkg::*;
#(
    parameter bit ALT_PACKAGE = 1'b0,
    parameter bit NARROW      = 1'b0,
    localparam int CELLS      = ALT_PACKAGE ? 89 : 85
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [CELLS-1:0] pin_capture,
    output logic             tdo,
    output logic             tdo_oe,
    output logic [CELLS-1:0] pin_update,
    output logic             out_hiz
);

    localparam logic [2:0]  REV_F   = 3'b000;
    localparam logic [4:0]  DEPTH_F = 5'b01011;
    localparam logic [5:0]  ARCH_F  = ALT_PACKAGE ? 6'b000000 : 6'b101000;
    localparam logic [5:0]  DEV_F   = NARROW ? 6'b010101 : 6'b100101;
    localparam logic [10:0] MFR_F   = 11'b00000110100;
    localparam logic [31:0] ID_WORD = {REV_F, DEPTH_F, ARCH_F, DEV_F, MFR_F, 1'b1};

    tap_state_e state;
    tap_op_e    op;
    logic       ir_so, dr_so;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
        .op(op), .ir_so(ir_so), .out_hiz(out_hiz)
    );

    tap_dr #(.CELLS(CELLS), .ID_WORD(ID_WORD)) u_dr (
        .tck(tck), .trst_n(trst_n), .state(state), .op(op), .tdi(tdi),
        .pin_capture(pin_capture), .dr_so(dr_so), .pin_update(pin_update)
    );

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == SH_IR) ? ir_so : dr_so;
            tdo_oe <= (state == SH_IR) || (state == SH_DR);
        end
    end

    AST_OE_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == SH_IR || state == SH_DR));  // R10
    AST_HIZ_CODES: assert property (@(posedge tck) disable iff (!trst_n)
        out_hiz |-> (op == OP_EXTEST || op == OP_PROBE_HIZ));  // R9

endmodule

// File: tb/sram_tap_port_test.sv
module sram_tap_port_test;

    localparam int C0 = 85;
    localparam int C1 = 89;
    localparam int N  = C1 + 8;

    logic tck = 1'b0;
    logic trst_n, tms, tdi;
    logic [C0-1:0] cap0, upd0;
    logic [C1-1:0] cap1, upd1;
    logic tdo0, oe0, hiz0, tdo1, oe1, hiz1;

    int checks = 0;
    int errors = 0;

    always #4 tck = ~tck;

    sram_tap_port uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_capture(cap0),
        .tdo(tdo0), .tdo_oe(oe0), .pin_update(upd0), .out_hiz(hiz0)
    );

    sram_tap_port #(.ALT_PACKAGE(1'b1), .NARROW(1'b1)) uut_alt (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_capture(cap1),
        .tdo(tdo1), .tdo_oe(oe1), .pin_update(upd1), .out_hiz(hiz1)
    );

    localparam logic [31:0] ID0 = {3'b000, 5'b01011, 6'b101000, 6'b100101, 11'b00000110100, 1'b1};
    localparam logic [31:0] ID1 = {3'b000, 5'b01011, 6'b000000, 6'b010101, 11'b00000110100, 1'b1};

    function automatic logic pat(int i);
        return ((i * 5 + 3) % 7) < 3;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    // from RTI; returns serial outputs of both instances
    task automatic dr_scan(output logic [127:0] o0, output logic [127:0] o1, output bit oe_ok);
        o0 = '0; o1 = '0; oe_ok = 1'b1;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < N; i++) begin
            o0[i] = tdo0; o1[i] = tdo1;
            if (!(oe0 && oe1)) oe_ok = 1'b0;
            tick(i == N - 1, pat(i));
        end
        if (oe0 || oe1) oe_ok = 1'b0;
        tick(1, 0); tick(0, 0);
    endtask

    task automatic ir_scan(input logic [2:0] code, output logic [2:0] got0, output bit held);
        logic h0, h1;
        h0 = hiz0; h1 = hiz1;
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 3; i++) begin
            got0[i] = tdo0;
            tick(i == 2, code[i]);
        end
        held = (hiz0 == h0) && (hiz1 == h1);
        tick(1, 0); tick(0, 0);
    endtask

    task automatic expect_id(input string tag);
        logic [127:0] o0, o1, e0, e1;
        bit ok;
        dr_scan(o0, o1, ok);
        e0 = '0; e1 = '0;
        for (int i = 0; i < N; i++) begin
            e0[i] = (i < 32) ? ID0[i] : pat(i - 32);
            e1[i] = (i < 32) ? ID1[i] : pat(i - 32);
        end
        chk(o0 == e0, {tag, " id x36/85"}, o0, e0);
        chk(o1 == e1, {tag, " id x18/89"}, o1, e1);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired R1 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] o0, o1, e0, e1;
        logic [C0-1:0] eu0;
        logic [C1-1:0] eu1;
        logic [2:0] got;
        bit ok, held;
        for (int k = 0; k < C0; k++) cap0[k] = (k % 3 == 0) ^ (k % 5 == 1);
        for (int k = 0; k < C1; k++) cap1[k] = (k % 4 == 2) | (k % 7 == 0);
        eu0 = '0; eu1 = '0;
        tms = 1'b1; tdi = 1'b0; trst_n = 1'b0;
        repeat (3) @(negedge tck);
        #1 trst_n = 1'b1;
        // R2 reset state
        chk(!hiz0 && !hiz1 && !oe0 && !oe1, "R2 reset outputs", {hiz0, hiz1, oe0, oe1}, 0);
        chk(upd0 == '0 && upd1 == '0, "R8 reset update vector", upd0, 0);
        tick(0, 0);
        expect_id("R5 R11 R2 reset IDCODE");

        // sweep every opcode: R3 R4 R6 R7 R8 R9
        for (int c = 0; c < 8; c++) begin
            bit is_bsr, is_hiz;
            is_bsr = (c == 0) || (c == 2) || (c == 4);
            is_hiz = (c == 0) || (c == 2);
            ir_scan(c[2:0], got, held);
            chk(got == 3'b001, $sformatf("R3 capture-IR code %0d", c), got, 3'b001);
            chk(held, $sformatf("R4 no change before update code %0d", c), hiz0, 0);
            chk(hiz0 == is_hiz && hiz1 == is_hiz, $sformatf("R9 out_hiz code %0d", c), {hiz0, hiz1}, {is_hiz, is_hiz});
            dr_scan(o0, o1, ok);
            chk(ok, $sformatf("R10 tdo_oe code %0d", c), ok, 1);
            e0 = '0; e1 = '0;
            for (int i = 0; i < N; i++) begin
                if (c == 1) begin
                    e0[i] = (i < 32) ? ID0[i] : pat(i - 32);
                    e1[i] = (i < 32) ? ID1[i] : pat(i - 32);
                end else if (is_bsr) begin
                    e0[i] = (i < C0) ? cap0[i] : pat(i - C0);
                    e1[i] = (i < C1) ? cap1[i] : pat(i - C1);
                end else begin
                    e0[i] = (i == 0) ? 1'b0 : pat(i - 1);
                    e1[i] = e0[i];
                end
            end
            chk(o0 == e0, $sformatf("R5 R6 R7 scan 85-cell code %0d", c), o0, e0);
            chk(o1 == e1, $sformatf("R6 R7 R11 scan 89-cell code %0d", c), o1, e1);
            if (is_bsr) begin
                for (int k = 0; k < C0; k++) eu0[k] = pat(N - C0 + k);
                for (int k = 0; k < C1; k++) eu1[k] = pat(N - C1 + k);
            end
            chk(upd0 == eu0, $sformatf("R8 update 85 code %0d", c), upd0, eu0);
            chk(upd1 == eu1, $sformatf("R8 update 89 code %0d", c), upd1, eu1);
        end

        // R1 five TMS highs return to TLR from RTI with EXTEST active
        ir_scan(3'b000, got, held);
        chk(hiz0, "R9 EXTEST floats", hiz0, 1);
        for (int i = 0; i < 5; i++) tick(1, 0);
        chk(!hiz0 && !hiz1, "R1 R2 five-TMS reset", {hiz0, hiz1}, 0);
        tick(0, 0);
        expect_id("R1 after TMS reset");

        // R1 asynchronous reset from BYPASS
        ir_scan(3'b111, got, held);
        #1 trst_n = 1'b0;
        #3 trst_n = 1'b1;
        @(negedge tck); #1;
        chk(!oe0 && !hiz0, "R1 trst outputs", {oe0, hiz0}, 0);
        tick(0, 0);
        expect_id("R1 after trst");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule